// File: doc/BRIEF.md
# Bus Transfer-Error Status Capture

This block sits beside a bus controller and decides, each cycle, whether a transfer must be terminated with an error acknowledge. It also records the reason in sticky status flags. Six single-cycle event strobes come in from neighbouring logic: a bus-monitor timeout, an error on an internal-space access, a bus parity error, an uncorrectable (double-bit) ECC error, a corrected (single-bit) ECC error and a write to a read-only region. The block turns them into a one-cycle acknowledge request and a set of flags that software can read.

Hard errors always request the acknowledge. Parity errors request it unless software has masked them. A corrected ECC error is normally only counted in a saturating counter. Once that counter is full, every further corrected error is escalated to an acknowledge and flagged. A write-protect violation is flagged but never requests the acknowledge. Software reads a single 32-bit word, clears flags by writing ones to them, sets the parity mask, and clears the counter through a write-only strobe bit.

The acknowledge path is a two-state machine. `ACK_IDLE` moves to `ACK_FIRE` when a qualifying event is seen. `ACK_FIRE` stays in `ACK_FIRE` when another qualifying event arrives and otherwise returns to `ACK_IDLE`. The acknowledge request is asserted only in `ACK_FIRE`.

Top module: `xfer_err_capture`

## Requirements
- R1: After reset, `rd_data` reads all zeros and `ack_req` is low.
- R2: Read layout of `rd_data`:
  - bit 31 bus-monitor flag, bit 30 internal-space flag, bit 29 parity flag, bit 28 double-ECC flag, bit 27 single-ECC flag, bit 26 write-protect flag;
  - bit 8 parity-acknowledge mask;
  - bits 7:0 the ECC error counter;
  - every other bit reads 0.
- R3: A bus-monitor, internal-space or double-ECC event sets its flag and makes `ack_req` high in the cycle after the event.
- R4: A parity event always sets the parity flag. It raises `ack_req` in the next cycle only while the mask (bit 8) is 0.
- R5: A single-ECC event increments the counter, which saturates at 255. When the counter held less than 255 at the time of the event, no acknowledge is raised and the single-ECC flag is not set.
- R6: When the counter holds 255 at the time of a single-ECC event, the single-ECC flag is set, `ack_req` is high in the next cycle, and the counter stays at 255.
- R7: A write-protect event sets its flag and never raises `ack_req`.
- R8: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. An event in the same cycle as a clear of its flag leaves the flag set.
- R9: A write with bit 9 set clears the counter. A single-ECC event in that same cycle leaves the counter at 1. Bit 9 always reads 0.
- R10: `ack_req` is high for exactly one cycle per cycle that holds a qualifying event, so qualifying events in back-to-back cycles give back-to-back high cycles.
- R11: Every write loads the parity mask from bit 8 of the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_bus_tmo | input | 1 | Bus-monitor timeout strobe |
| evt_int_err | input | 1 | Internal-space access error strobe |
| evt_parity | input | 1 | Bus parity error strobe |
| evt_ecc_dbl | input | 1 | Double-bit ECC error strobe |
| evt_ecc_sgl | input | 1 | Single-bit (corrected) ECC error strobe |
| evt_wr_prot | input | 1 | Write to read-only region strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| ack_req | output | 1 | Transfer-error acknowledge request pulse |

## Verification
The bench drives the counter all the way to saturation. It then checks that the event that makes the counter reach 255 is still silent, while the next one is escalated. A design that compared against the updated value, or that wrapped the counter to zero, would fail here. The bench also hits a flag clear and its event in the same cycle, and a counter clear together with a single-ECC event. In both cases a design with the wrong priority would lose an error. Finally, it checks the masked parity and write-protect paths: the flag must still be captured, but `ack_req` must stay low. It also checks that back-to-back qualifying events keep the acknowledge high for two cycles, where a design that wrongly returned to `ACK_IDLE` would drop the second pulse.

// File: rtl/xerr_pkg.sv
package xerr_pkg;
    localparam int REG_W   = 32;
    localparam int NFLAG   = 6;
    localparam int CTL_POS = 8;
    localparam int CLR_POS = 9;

    localparam int FLG_BM  = 0;
    localparam int FLG_ISE = 1;
    localparam int FLG_PAR = 2;
    localparam int FLG_DBL = 3;
    localparam int FLG_SBE = 4;
    localparam int FLG_WP  = 5;

    typedef enum logic {
        ACK_IDLE = 1'b0,
        ACK_FIRE = 1'b1
    } ack_state_t;
endpackage

// File: rtl/xerr_ecc_counter.sv
module xerr_ecc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign sat = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_ONE : '0;
        end else if (inc && !sat) begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/xerr_ack_fsm.sv
module xerr_ack_fsm
    import xerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic ack
);
    ack_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: if (qual)  state_d = ACK_FIRE;
            ACK_FIRE: if (!qual) state_d = ACK_IDLE;
            default:             state_d = ACK_IDLE;
        endcase
    end

    always_comb begin
        ack = (state_q == ACK_FIRE);
    end
endmodule

// File: rtl/xerr_status_flags.sv
module xerr_status_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/xfer_err_capture.sv
module xfer_err_capture
    import xerr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_bus_tmo,
    input  logic        evt_int_err,
    input  logic        evt_parity,
    input  logic        evt_ecc_dbl,
    input  logic        evt_ecc_sgl,
    input  logic        evt_wr_prot,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        ack_req
);
    logic [CNT_W-1:0] cnt;
    logic             sat;
    logic             par_mask;
    logic [NFLAG-1:0] flag_set, flag_clr, flags;
    logic             qual;

    xerr_ecc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(evt_ecc_sgl),
        .clr(wr_en && wr_data[CLR_POS]), .cnt(cnt), .sat(sat)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_BM]  = evt_bus_tmo;
        flag_set[FLG_ISE] = evt_int_err;
        flag_set[FLG_PAR] = evt_parity;
        flag_set[FLG_DBL] = evt_ecc_dbl;
        flag_set[FLG_SBE] = evt_ecc_sgl && sat;
        flag_set[FLG_WP]  = evt_wr_prot;
        for (int i = 0; i < NFLAG; i++) begin
            flag_clr[i] = wr_en && wr_data[REG_W-1-i];
        end
    end

    xerr_status_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flags)
    );

    always_comb begin
        qual = evt_bus_tmo || evt_int_err || evt_ecc_dbl
            || (evt_parity && !par_mask)
            || (evt_ecc_sgl && sat);
    end

    xerr_ack_fsm u_ack (
        .clk(clk), .rst_n(rst_n), .qual(qual), .ack(ack_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     par_mask <= 1'b0;
        else if (wr_en) par_mask <= wr_data[CTL_POS];
    end

    always_comb begin
        rd_data            = '0;
        rd_data[CNT_W-1:0] = cnt;
        rd_data[CTL_POS]   = par_mask;
        for (int i = 0; i < NFLAG; i++) begin
            rd_data[REG_W-1-i] = flags[i];
        end
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[REG_W-NFLAG-1:CLR_POS+1], wr_data[CTL_POS-1:0]};
endmodule

// File: rtl/xerr_capture_chk.sv
module xerr_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_bus_tmo,
    input logic        evt_int_err,
    input logic        evt_parity,
    input logic        evt_ecc_dbl,
    input logic        evt_ecc_sgl,
    input logic        evt_wr_prot,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        ack_req
);
    logic hard;
    assign hard = evt_bus_tmo || evt_int_err || evt_ecc_dbl;

    a_r3_hard_ack: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> ack_req);

    a_r4_par_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_parity && rd_data[8] && !hard && !evt_ecc_sgl) |=> !ack_req);

    a_r5_sbe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ecc_sgl && rd_data[7:0] != 8'hFF && !hard && !evt_parity) |=> !ack_req);

    a_r6_sbe_sat_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ecc_sgl && rd_data[7:0] == 8'hFF) |=> (ack_req && rd_data[27]));

    a_r7_wp_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr_prot && !hard && !evt_parity && !evt_ecc_sgl) |=> (!ack_req && rd_data[26]));

    a_r8_bm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31] && !(wr_en && wr_data[31])) |=> rd_data[31]);

    a_r9_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[9] && !evt_ecc_sgl) |=> (rd_data[7:0] == 8'h00));

    a_r9_clr_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[9]);
endmodule

bind xfer_err_capture xerr_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_bus_tmo(evt_bus_tmo), .evt_int_err(evt_int_err),
    .evt_parity(evt_parity), .evt_ecc_dbl(evt_ecc_dbl), .evt_ecc_sgl(evt_ecc_sgl),
    .evt_wr_prot(evt_wr_prot), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ack_req(ack_req)
);

// File: tb/tb_xfer_err_capture.sv
`timescale 1ns/1ps
module tb_xfer_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_bus_tmo = 0, evt_int_err = 0, evt_parity = 0;
    logic        evt_ecc_dbl = 0, evt_ecc_sgl = 0, evt_wr_prot = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ack_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xfer_err_capture dut (
        .clk(clk), .rst_n(rst_n), .evt_bus_tmo(evt_bus_tmo), .evt_int_err(evt_int_err),
        .evt_parity(evt_parity), .evt_ecc_dbl(evt_ecc_dbl), .evt_ecc_sgl(evt_ecc_sgl),
        .evt_wr_prot(evt_wr_prot), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ack_req(ack_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // advance one edge, sample 1 ns after it
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic quiet();
        {evt_bus_tmo, evt_int_err, evt_parity, evt_ecc_dbl, evt_ecc_sgl, evt_wr_prot} = '0;
        wr_en = 0; wr_data = '0;
    endtask

    task automatic reg_write(input logic [31:0] d);
        wr_en = 1; wr_data = d; step(); quiet();
    endtask

    task automatic t_reset();
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 ack", {31'b0, ack_req}, 32'h0);
    endtask

    task automatic t_hard();
        evt_bus_tmo = 1; step(); quiet();
        chk("R3 bm ack", {31'b0, ack_req}, 1);
        chk("R2 bm flag bit31", rd_data, 32'h8000_0000);
        step();
        chk("R10 ack single", {31'b0, ack_req}, 0);
        evt_int_err = 1; step(); quiet();
        chk("R3 ise ack", {31'b0, ack_req}, 1);
        evt_ecc_dbl = 1; step(); quiet();
        chk("R3 dbl ack", {31'b0, ack_req}, 1);
        chk("R2 flags", rd_data, 32'hD000_0000);
        reg_write(32'h0000_0000);
        chk("R8 write zero keeps", rd_data, 32'hD000_0000);
        reg_write(32'h4000_0000);
        chk("R8 w1c ise", rd_data, 32'h9000_0000);
        wr_en = 1; wr_data = 32'h9000_0000; evt_bus_tmo = 1; step(); quiet();
        chk("R8 set beats clear", rd_data, 32'h8000_0000);
        reg_write(32'hFC00_0000);
        chk("R8 clear all", rd_data, 32'h0);
    endtask

    task automatic t_back_to_back();
        evt_int_err = 1; step();
        chk("R10 b2b first", {31'b0, ack_req}, 1);
        step(); quiet();
        chk("R10 b2b second", {31'b0, ack_req}, 1);
        step();
        chk("R10 b2b end", {31'b0, ack_req}, 0);
        reg_write(32'hFC00_0000);
    endtask

    task automatic t_parity();
        evt_parity = 1; step(); quiet();
        chk("R4 par ack unmasked", {31'b0, ack_req}, 1);
        reg_write(32'hFC00_0100);
        chk("R11 mask set", rd_data, 32'h0000_0100);
        evt_parity = 1; step(); quiet();
        chk("R4 par masked no ack", {31'b0, ack_req}, 0);
        chk("R4 par flag", rd_data, 32'h2000_0100);
        reg_write(32'h2000_0000);
        chk("R11 mask cleared", rd_data, 32'h0);
    endtask

    task automatic t_wp();
        evt_wr_prot = 1; step(); quiet();
        chk("R7 wp no ack", {31'b0, ack_req}, 0);
        chk("R7 wp flag", rd_data, 32'h0400_0000);
        reg_write(32'h0400_0000);
    endtask

    task automatic t_ecc();
        int bad_ack = 0;
        for (int i = 0; i < 3; i++) begin
            evt_ecc_sgl = 1; step(); quiet();
            if (ack_req) bad_ack++;
        end
        chk("R5 count three", rd_data, 32'h0000_0003);
        for (int i = 3; i < 255; i++) begin
            evt_ecc_sgl = 1; step(); quiet();
            if (ack_req) bad_ack++;
        end
        chk("R5 no ack below max", bad_ack, 0);
        chk("R5 reached 255 no flag", rd_data, 32'h0000_00FF);
        evt_ecc_sgl = 1; step(); quiet();
        chk("R6 sat ack", {31'b0, ack_req}, 1);
        chk("R6 sat flag held", rd_data, 32'h0800_00FF);
        wr_en = 1; wr_data = 32'h0800_0200; evt_ecc_sgl = 1; step(); quiet();
        chk("R9 clear with event", rd_data, 32'h0800_0001);
        reg_write(32'h0000_0200);
        chk("R9 clear counter bit9 reads 0", rd_data, 32'h0800_0000);
        reg_write(32'h0800_0000);
    endtask

    initial begin
        quiet();
        repeat (3) step();
        t_reset();
        rst_n = 1; step();
        t_reset();
        t_hard();
        t_back_to_back();
        t_parity();
        t_wp();
        t_ecc();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule